// File: doc/BRIEF.md
# HDB3 Line Encoder and Decoder

This block turns a serial binary stream into a bipolar HDB3 symbol stream carried on two rails, one for positive pulses and one for negative pulses, and turns a received two-rail stream back into binary. Ones become pulses of alternating polarity. Each run of four zeros is replaced by a substitution pattern that ends in a deliberate polarity violation, so the line never goes quiet for long. A balancing pulse is added at the start of the pattern when needed, so that successive violations alternate in polarity and the line stays DC-free.

Both directions advance on a bit-rate clock enable. Each direction has a fixed look-ahead of four bit periods. The receiver accepts legal substitution patterns and turns them back into zeros. It raises a per-bit code-error flag for any violation the substitution rule cannot explain, and for a symbol that arrives on both rails at once. The flag needs no knowledge of the payload. Typical use is between a framer and a line interface unit, with clock recovery and pulse shaping handled elsewhere.

Top module: `hdb3_codec`

## Requirements
- R1: A one on `tx_bit` is sent as a single pulse on exactly one rail (`tx_pos`=1 means positive, `tx_neg`=1 means negative). Successive mark pulses alternate in polarity. The first mark after reset is positive.
- R2: After the line has filled following reset, the transmit rails never carry more than three zero symbols in a row.
- R3: A run of four zeros that follows an odd number of pulses since the last violation is sent as 0,0,0,V. V has the same polarity as the pulse before it.
- R4: A run of four zeros that follows an even number of pulses since the last violation (reset counts as even) is sent as B,0,0,V. B has the opposite polarity to the pulse before it, and V repeats the polarity of B.
- R5: Successive violation pulses on the transmit rails have opposite polarity.
- R6: A bit presented at an enable appears on the transmit rails after the fourth later enable edge. All outputs change only at clock edges where `bit_en` is high.
- R7: A received violation whose two preceding symbols are zeros is a substitution pattern. The violation, those two zeros and the symbol before them (zero or balancing pulse) decode as four zeros, with no error flag.
- R8: A received violation that is not preceded by two zeros decodes as a one, with `rx_cerr` high for that bit. A transmit stream looped back to the receiver never raises `rx_cerr`.
- R9: A symbol with both rails high decodes as a zero, with `rx_cerr` high, and does not change the receiver's remembered polarity.
- R10: A received symbol is decoded onto `rx_bit` after the fourth later enable edge, and `rx_cerr` is aligned with that same bit. A looped-back stream returns the original bits.
- R11: Reset is synchronous and active high. After reset both transmit rails, `rx_bit` and `rx_cerr` are low, and both directions assume that the last pulse was negative.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | One-cycle strobe per bit period |
| tx_bit | input | 1 | Binary data to encode |
| tx_pos | output | 1 | Positive pulse on the transmit line |
| tx_neg | output | 1 | Negative pulse on the transmit line |
| rx_pos | input | 1 | Positive pulse from the receive line |
| rx_neg | input | 1 | Negative pulse from the receive line |
| rx_bit | output | 1 | Decoded binary data |
| rx_cerr | output | 1 | Code error flag for the bit on `rx_bit` |

## Verification
The bench counts enables from reset. The symbol for input bit k is read after enable edge k+4. A receive symbol driven at enable j is decoded after enable edge j+4. In loopback, the receiver latches each transmit symbol one enable after it appears, so decoded bit k is read after enable edge k+9. All sampling happens on the falling clock edge one cycle after each enable. Expected values are indexed with these fixed offsets. The hold behaviour is checked on every idle cycle between enables.

// File: rtl/hdb3_pkg.sv
package hdb3_pkg;
  // one slot of the transmit look-ahead line
  typedef struct packed {
    logic live;   // holds a real input bit (not reset fill)
    logic mark;   // input bit was one
    logic head;   // first zero of a substituted run
    logic viol;   // last zero of a substituted run
  } enc_slot_t;

  // one slot of the receive delay line
  typedef struct packed {
    logic one;    // decoded data bit
    logic err;    // code error attached to this bit
  } dec_slot_t;
endpackage

// File: rtl/hdb3_enc.sv
module hdb3_enc
  import hdb3_pkg::*;
#(
  parameter int RUN_LEN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic din,
  output logic pos,
  output logic neg
);
  localparam int DEPTH = RUN_LEN;
  localparam int WIN   = RUN_LEN - 1;

  enc_slot_t line_q [DEPTH];
  enc_slot_t line_d [DEPTH];
  enc_slot_t out_s;
  logic      run_ok;
  logic      last_q, last_d;   // 1: last pulse positive
  logic      odd_q, odd_d;     // pulses since last violation is odd
  logic      pos_d, neg_d;

  // a full zero run when the new bit and the newest WIN slots are plain zeros
  always_comb begin
    run_ok = !din;
    for (int i = 0; i < WIN; i++) begin
      run_ok = run_ok && line_q[i].live && !line_q[i].mark &&
               !line_q[i].viol && !line_q[i].head;
    end
  end

  always_comb begin
    line_d[0] = '{live: 1'b1, mark: din, head: 1'b0, viol: run_ok};
    for (int i = 1; i < DEPTH; i++) begin
      line_d[i] = line_q[i-1];
      if (run_ok && i == DEPTH - 1) line_d[i].head = 1'b1;
    end
  end

  assign out_s = line_q[DEPTH-1];

  always_comb begin
    pos_d  = 1'b0;
    neg_d  = 1'b0;
    last_d = last_q;
    odd_d  = odd_q;
    if (out_s.viol) begin
      pos_d = last_q;
      neg_d = !last_q;
      odd_d = 1'b0;
    end else if (out_s.mark || (out_s.head && !odd_q)) begin
      pos_d  = !last_q;
      neg_d  = last_q;
      last_d = !last_q;
      odd_d  = !odd_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) line_q[i] <= '0;
      pos    <= 1'b0;
      neg    <= 1'b0;
      last_q <= 1'b0;
      odd_q  <= 1'b0;
    end else if (en) begin
      for (int i = 0; i < DEPTH; i++) line_q[i] <= line_d[i];
      pos    <= pos_d;
      neg    <= neg_d;
      last_q <= last_d;
      odd_q  <= odd_d;
    end
  end
endmodule

// File: rtl/hdb3_dec.sv
module hdb3_dec
  import hdb3_pkg::*;
#(
  parameter int RUN_LEN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic pin,
  input  logic nin,
  output logic dout,
  output logic cerr
);
  localparam int DEPTH = RUN_LEN;
  localparam int GAP   = RUN_LEN - 2;   // zeros required before a violation
  localparam int CLR   = RUN_LEN - 2;   // oldest slot index cleared on a match

  dec_slot_t line_q [DEPTH];
  dec_slot_t line_d [DEPTH];
  logic      last_q, last_d;   // 1: last pulse positive
  logic      both, pulse, viol, gap_ok, legal;

  assign both  = pin && nin;
  assign pulse = pin ^ nin;
  assign viol  = pulse && (pin == last_q);

  always_comb begin
    gap_ok = 1'b1;
    for (int i = 0; i < GAP; i++) begin
      gap_ok = gap_ok && !line_q[i].one && !line_q[i].err;
    end
  end

  assign legal  = viol && gap_ok;
  assign last_d = pulse ? pin : last_q;

  always_comb begin
    line_d[0].one = pulse && !legal;
    line_d[0].err = both || (viol && !legal);
    for (int i = 1; i < DEPTH; i++) begin
      line_d[i] = line_q[i-1];
      if (legal && (i - 1) <= CLR) line_d[i].one = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) line_q[i] <= '0;
      last_q <= 1'b0;
      dout   <= 1'b0;
      cerr   <= 1'b0;
    end else if (en) begin
      for (int i = 0; i < DEPTH; i++) line_q[i] <= line_d[i];
      last_q <= last_d;
      dout   <= line_q[DEPTH-1].one;
      cerr   <= line_q[DEPTH-1].err;
    end
  end
endmodule

// File: rtl/hdb3_codec.sv
module hdb3_codec #(
  parameter int RUN_LEN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_en,
  input  logic tx_bit,
  output logic tx_pos,
  output logic tx_neg,
  input  logic rx_pos,
  input  logic rx_neg,
  output logic rx_bit,
  output logic rx_cerr
);
  hdb3_enc #(.RUN_LEN(RUN_LEN)) u_enc (
    .clk (clk),
    .rst (rst),
    .en  (bit_en),
    .din (tx_bit),
    .pos (tx_pos),
    .neg (tx_neg)
  );

  hdb3_dec #(.RUN_LEN(RUN_LEN)) u_dec (
    .clk  (clk),
    .rst  (rst),
    .en   (bit_en),
    .pin  (rx_pos),
    .nin  (rx_neg),
    .dout (rx_bit),
    .cerr (rx_cerr)
  );
endmodule

// File: rtl/hdb3_codec_chk.sv
module hdb3_codec_chk (
  input logic clk,
  input logic rst,
  input logic bit_en,
  input logic tx_pos,
  input logic tx_neg,
  input logic rx_bit,
  input logic rx_cerr
);
  localparam int FILL = 5;   // zero symbols seen before the first real one

  logic [2:0] warm_q;
  logic [2:0] zrun_q;
  logic       lastp_q, have_v_q, vpol_q;
  logic       warm_done, pulse, is_v;

  assign warm_done = (warm_q == 3'(FILL));
  assign pulse     = tx_pos ^ tx_neg;
  assign is_v      = pulse && (tx_pos == lastp_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      warm_q   <= '0;
      zrun_q   <= '0;
      lastp_q  <= 1'b0;
      have_v_q <= 1'b0;
      vpol_q   <= 1'b0;
    end else if (bit_en) begin
      if (!warm_done) warm_q <= warm_q + 3'd1;
      else begin
        if (pulse) begin
          zrun_q  <= '0;
          lastp_q <= tx_pos;
        end else if (zrun_q != 3'd7) zrun_q <= zrun_q + 3'd1;
        if (is_v) begin
          have_v_q <= 1'b1;
          vpol_q   <= tx_pos;
        end
      end
    end
  end

  // R1: a transmit symbol never drives both rails
  a_r1_rails_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(tx_pos && tx_neg));

  // R2: at most three zero symbols in a row once the line is filled
  a_r2_zero_run: assert property (@(posedge clk) disable iff (rst)
    (bit_en && warm_done && !pulse) |-> (zrun_q < 3'd3));

  // R5: successive violations alternate in polarity
  a_r5_viol_alternate: assert property (@(posedge clk) disable iff (rst)
    (bit_en && warm_done && is_v && have_v_q) |-> (tx_pos != vpol_q));

  // R6: outputs hold while the bit enable is low
  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    !bit_en |=> ($stable(tx_pos) && $stable(tx_neg) &&
                 $stable(rx_bit) && $stable(rx_cerr)));
endmodule

bind hdb3_codec hdb3_codec_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .bit_en  (bit_en),
  .tx_pos  (tx_pos),
  .tx_neg  (tx_neg),
  .rx_bit  (rx_bit),
  .rx_cerr (rx_cerr)
);

// File: tb/sim_hdb3_codec.sv
module sim_hdb3_codec;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_en = 1'b0;
  logic tx_bit = 1'b0;
  logic drv_p = 1'b0, drv_n = 1'b0, loop_q = 1'b0;
  logic tx_pos, tx_neg, rx_bit, rx_cerr;
  logic rx_pos, rx_neg;

  int checks = 0;
  int errors = 0;

  logic       bits [0:127];
  logic [1:0] sym  [0:127];
  logic [1:0] txs  [0:127];
  logic       rxb  [0:127];
  logic       rxe  [0:127];
  logic [1:0] dsym [0:31];
  logic       dexb [0:31];
  logic       dexe [0:31];

  assign rx_pos = loop_q ? tx_pos : drv_p;
  assign rx_neg = loop_q ? tx_neg : drv_n;

  always #10 clk = ~clk;

  hdb3_codec u0 (
    .clk(clk), .rst(rst), .bit_en(bit_en), .tx_bit(tx_bit),
    .tx_pos(tx_pos), .tx_neg(tx_neg), .rx_pos(rx_pos), .rx_neg(rx_neg),
    .rx_bit(rx_bit), .rx_cerr(rx_cerr)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; bit_en = 1'b0; tx_bit = 1'b0; drv_p = 1'b0; drv_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  // one bit period: enable for one cycle, sample, then idle gap cycles
  task automatic tick(input logic b, input logic [1:0] r, input int gap, input int m);
    @(negedge clk);
    tx_bit = b; drv_p = r[1]; drv_n = r[0]; bit_en = 1'b1;
    @(negedge clk);
    bit_en = 1'b0;
    txs[m] = {tx_pos, tx_neg};
    rxb[m] = rx_bit;
    rxe[m] = rx_cerr;
    for (int g = 0; g < gap; g++) begin
      @(negedge clk);
      chk("R6", "hold between enables", int'({tx_pos, tx_neg, rx_bit, rx_cerr}),
          int'({txs[m], rxb[m], rxe[m]}));
    end
  endtask

  task automatic fill_tail(input int n);
    for (int i = n; i < 128; i++) bits[i] = 1'b1;
  endtask

  // forward-scan reference for the line code
  task automatic model();
    int  i;
    logic lp, od;
    lp = 1'b0; od = 1'b0; i = 0;
    while (i < 128) begin
      if (bits[i]) begin
        sym[i] = lp ? 2'b01 : 2'b10; lp = !lp; od = !od; i++;
      end else if (i + 3 < 128 && !bits[i+1] && !bits[i+2] && !bits[i+3]) begin
        if (od) sym[i] = 2'b00;
        else begin sym[i] = lp ? 2'b01 : 2'b10; lp = !lp; end
        sym[i+1] = 2'b00; sym[i+2] = 2'b00;
        sym[i+3] = lp ? 2'b10 : 2'b01;
        od = 1'b0; i += 4;
      end else begin
        sym[i] = 2'b00; i++;
      end
    end
  endtask

  task automatic run_stream(input int n, input int gap, input string tag);
    model();
    loop_q = 1'b1;
    do_reset();
    for (int m = 0; m <= n + 8; m++) tick(bits[m], 2'b00, gap, m);
    for (int k = 0; k < n; k++) begin
      chk(tag, $sformatf("tx symbol %0d", k), int'(txs[k+4]), int'(sym[k]));
      chk("R10", $sformatf("loopback bit %0d", k), int'(rxb[k+9]), int'(bits[k]));
      chk("R8", $sformatf("no false code error %0d", k), int'(rxe[k+9]), 0);
    end
    loop_q = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    @(negedge clk);
    chk("R11", "rails after reset", int'({tx_pos, tx_neg}), 0);
    chk("R11", "rx outputs after reset", int'({rx_bit, rx_cerr}), 0);
  endtask

  task automatic t_ones();
    for (int i = 0; i < 16; i++) bits[i] = 1'b1;
    fill_tail(16);
    run_stream(16, 0, "R1");
    chk("R1", "first mark positive", int'(txs[4]), 2);
    chk("R1", "second mark negative", int'(txs[5]), 1);
  endtask

  task automatic t_zeros();
    for (int i = 0; i < 16; i++) bits[i] = 1'b0;
    fill_tail(16);
    run_stream(16, 1, "R4");
    chk("R4", "first B positive", int'(txs[4]), 2);
    chk("R4", "first V same as B", int'(txs[7]), 2);
    chk("R4", "second B negative", int'(txs[8]), 1);
    chk("R4", "second V negative", int'(txs[11]), 1);
  endtask

  task automatic t_odd();
    bits[0] = 1'b1;
    for (int i = 1; i < 5; i++) bits[i] = 1'b0;
    bits[5] = 1'b1; bits[6] = 1'b1;
    for (int i = 7; i < 11; i++) bits[i] = 1'b0;
    fill_tail(11);
    run_stream(11, 2, "R3");
    chk("R3", "no balancing pulse", int'(txs[5]), 0);
    chk("R3", "V repeats mark polarity", int'(txs[8]), 2);
    chk("R4", "even count gives B", int'(txs[11]), 1);
  endtask

  task automatic t_mixed();
    logic [31:0] pat;
    logic [15:0] lf;
    pat = 32'hB084_0361;
    for (int i = 0; i < 32; i++) bits[i] = pat[31-i];
    lf = 16'hACE1;
    for (int i = 32; i < 80; i++) begin
      bits[i] = lf[0] & lf[3];
      lf = {lf[0] ^ lf[2] ^ lf[3] ^ lf[5], lf[15:1]};
    end
    fill_tail(80);
    run_stream(80, 0, "R2");
  endtask

  task automatic t_decode();
    // + 0 0 0 +   - + 0 0 +   - 0 -   + +   both   - 0 0 0
    logic [1:0] s [0:19];
    s = '{2'b10,2'b00,2'b00,2'b00,2'b10, 2'b01,2'b10,2'b00,2'b00,2'b10,
          2'b01,2'b00,2'b01, 2'b10,2'b10, 2'b11, 2'b01,2'b00,2'b00,2'b00};
    for (int i = 0; i < 20; i++) begin dsym[i] = s[i]; dexb[i] = 1'b0; dexe[i] = 1'b0; end
    dexb[0] = 1'b1; dexb[5] = 1'b1; dexb[10] = 1'b1;
    dexb[12] = 1'b1; dexe[12] = 1'b1;
    dexb[13] = 1'b1; dexb[14] = 1'b1; dexe[14] = 1'b1;
    dexe[15] = 1'b1; dexb[16] = 1'b1;
    loop_q = 1'b0;
    do_reset();
    for (int m = 0; m < 24; m++) tick(1'b1, (m < 20) ? dsym[m] : 2'b00, 0, m);
    for (int k = 0; k < 20; k++) begin
      string rq;
      rq = (k < 10) ? "R7" : ((k == 15) ? "R9" : "R8");
      chk(rq, $sformatf("decoded bit %0d", k), int'(rxb[k+4]), int'(dexb[k]));
      chk("R10", $sformatf("code error flag %0d", k), int'(rxe[k+4]), int'(dexe[k]));
    end
    chk("R9", "both rails keep polarity", int'(rxe[20]), 0);
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_ones();
    t_zeros();
    t_odd();
    t_mixed();
    t_decode();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule